// File: doc/BRIEF.md
# Packed Halving Subtract-Add Crossed-Lane Unit

This block decodes and executes a single packed 16-bit instruction in the same cycle. The instruction can arrive in one of two formats. The first is a full 32-bit word that carries a condition code. The second is a pair of 16-bit halfwords that carries no condition. A format-select input chooses which of the two encodings is matched.

When the word matches, the block reports the three register indices it carries. It also forms a 32-bit result from the two source values it is given. The halfwords of the second source are crossed: the low lane adds, the high lane subtracts, and each lane keeps bits 16:1 of its 17-bit exact result. Carry and borrow are therefore never lost.

A surrounding pipeline supplies the register values and the current condition flags. It consumes the valid flag as a write enable and the unpredictable flag as a hazard marker. There is no state inside the block. Every output follows its inputs through a fixed logic path whose delay does not depend on the data.

Top module: `hsx_top`

## Requirements
- R1: result_o[15:0] equals bits 16:1 of the unsigned 17-bit sum op_a_i[15:0] + op_b_i[31:16].
- R2: result_o[31:16] equals bits 16:1 of the 17-bit two's-complement difference op_a_i[31:16] - op_b_i[15:0]; for example 0x0000 - 0x0001 gives 0xFFFF.
- R3: With fmt_sel_i = 0 (word format), a match needs word_i[27:20] = 8'b01100111, word_i[7:4] = 4'b0101 and word_i[31:28] != 4'b1111. In that format the first source index is word_i[19:16], the destination index is word_i[15:12] and the second source index is word_i[3:0].
- R4: With fmt_sel_i = 1 (halfword-pair format), the first halfword is word_i[31:16] and the second is word_i[15:0]. A match needs word_i[31:20] = 12'hFAE, word_i[15:12] = 4'hF and word_i[7:4] = 4'h6. In that format the first source index is word_i[19:16], the destination index is word_i[11:8] and the second source index is word_i[3:0].
- R5: In the word format, if word_i[11:8] holds any zero, the word still matches and executes, and unpred_o is raised.
- R6: On a match, unpred_o is raised when any of the three indices equals 15. Index 13 alone does not raise it.
- R7: In the word format, the condition word_i[31:28] is tested against flags_i, with N = [3], Z = [2], C = [1] and V = [0]:
  - 0000: Z
  - 0001: !Z
  - 0010: C
  - 0011: !C
  - 0100: N
  - 0101: !N
  - 0110: V
  - 0111: !V
  - 1000: C & !Z
  - 1001: !C | Z
  - 1010: N == V
  - 1011: N != V
  - 1100: !Z & N == V
  - 1101: Z | N != V
  - 1110: always passes
- R8: On a match whose condition fails, valid_o is 0 and result_o is 0. The indices and unpred_o are still reported.
- R9: In the halfword-pair format, the condition always passes and flags_i has no effect on any output.
- R10: A word that does not match drives valid_o, unpred_o, result_o and all three indices to zero.
- R11: All outputs settle from the current inputs without any clock. The delay is the same for every operand value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_sel_i | input | 1 | 0 = word format, 1 = halfword-pair format |
| word_i | input | 32 | Instruction bits |
| flags_i | input | 4 | Condition flags N, Z, C, V (bits 3..0) |
| op_a_i | input | 32 | First source value |
| op_b_i | input | 32 | Second source value |
| valid_o | output | 1 | Matched and condition passed (write enable) |
| rd_o | output | 4 | Destination index |
| rn_o | output | 4 | First source index |
| rm_o | output | 4 | Second source index |
| result_o | output | 32 | Packed halved result, zero unless valid_o |
| unpred_o | output | 1 | Matched with index 15 or with bad filler bits |

## Verification
The assertions are immediate checks on combinational logic, so they assume every input is a known 0 or 1. They are skipped while any input is unknown. The bench drives every input from the first step and changes them only on the falling clock edge, so no assertion sees unknown or half-changed values. The condition and lane checks also assume the decoder sees exactly one format per evaluation, which holds because fmt_sel_i is a single bit.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 2 * HALF_W;

  typedef enum logic {FMT_WORD = 1'b0, FMT_PAIR = 1'b1} fmt_e;

  typedef struct packed {
    logic             hit;
    logic             is_word;
    logic             pad_bad;
    logic [3:0]       cond;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rm;
  } dec_t;
endpackage

// File: rtl/hsx_decode.sv
module hsx_decode
  import hsx_pkg::*;
(
  input  logic              fmt_i,
  input  logic [WORD_W-1:0] word_i,
  output dec_t              dec_o
);
  logic word_hit_w, pair_hit_w;

  always_comb begin
    word_hit_w = (word_i[31:28] != 4'b1111) && (word_i[27:20] == 8'b0110_0111)
               && (word_i[7:4] == 4'b0101);
    pair_hit_w = (word_i[31:20] == 12'hFAE) && (word_i[15:12] == 4'hF)
               && (word_i[7:4] == 4'h6);
    dec_o = '0;
    if (fmt_i == FMT_PAIR) begin
      if (pair_hit_w) begin
        dec_o.hit  = 1'b1;
        dec_o.rn   = word_i[19:16];
        dec_o.rd   = word_i[11:8];
        dec_o.rm   = word_i[3:0];
        dec_o.cond = 4'b1110;
      end
    end else if (word_hit_w) begin
      dec_o.hit     = 1'b1;
      dec_o.is_word = 1'b1;
      dec_o.cond    = word_i[31:28];
      dec_o.rn      = word_i[19:16];
      dec_o.rd      = word_i[15:12];
      dec_o.rm      = word_i[3:0];
      dec_o.pad_bad = (word_i[11:8] != 4'hF);
    end
  end

  always_comb begin
    if (!$isunknown({fmt_i, word_i})) begin
      // R10
      miss_clear_chk: assert (dec_o.hit || dec_o == '0)
        else $error("decoder leaked fields on a miss");
      // R4
      pair_no_cond_chk: assert (!(dec_o.hit && !dec_o.is_word) || dec_o.cond == 4'b1110)
        else $error("pair format carried a condition");
    end
  end
endmodule

// File: rtl/hsx_cond.sv
module hsx_cond (
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);
  logic n, z, c, v, base;

  always_comb begin
    {n, z, c, v} = flags_i;
    unique case (cond_i[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    pass_o = (cond_i[3:1] == 3'b111) ? 1'b1 : (base ^ cond_i[0]);
  end

  always_comb begin
    if (!$isunknown({cond_i, flags_i})) begin
      // R7
      always_code_chk: assert (cond_i != 4'b1110 || pass_o)
        else $error("code 1110 failed");
    end
  end
endmodule

// File: rtl/hsx_lanes.sv
module hsx_lanes #(
  parameter int unsigned HW = 16
) (
  input  logic [2*HW-1:0] a_i,
  input  logic [2*HW-1:0] b_i,
  output logic [2*HW-1:0] res_o
);
  localparam int unsigned XW = HW + 1;

  function automatic logic [HW-1:0] half_add(input logic [HW-1:0] x, input logic [HW-1:0] y);
    logic [XW-1:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[XW-1:1];
  endfunction

  function automatic logic [HW-1:0] half_sub(input logic [HW-1:0] x, input logic [HW-1:0] y);
    logic [XW-1:0] d;
    d = {1'b0, x} - {1'b0, y};
    return d[XW-1:1];
  endfunction

  always_comb begin
    res_o[HW-1:0]    = half_add(a_i[HW-1:0], b_i[2*HW-1:HW]);
    res_o[2*HW-1:HW] = half_sub(a_i[2*HW-1:HW], b_i[HW-1:0]);
  end

  logic [XW:0]   raw_sum_w, twice_lo_w;
  logic [XW-1:0] back_w;

  always_comb begin
    raw_sum_w  = {2'b0, a_i[HW-1:0]} + {2'b0, b_i[2*HW-1:HW]};
    twice_lo_w = {1'b0, res_o[HW-1:0], 1'b0};
    back_w     = {res_o[2*HW-1:HW], 1'b0} + {1'b0, b_i[HW-1:0]} - {1'b0, a_i[2*HW-1:HW]};
    if (!$isunknown({a_i, b_i})) begin
      // R1
      lo_lane_chk: assert (raw_sum_w >= twice_lo_w && raw_sum_w - twice_lo_w <= 1)
        else $error("low lane off by more than the dropped bit");
      // R2
      hi_lane_chk: assert (back_w == '0 || back_w == '1)
        else $error("high lane off by more than the dropped bit");
    end
  end
endmodule

// File: rtl/hsx_top.sv
module hsx_top
  import hsx_pkg::*;
(
  input  logic        fmt_sel_i,
  input  logic [31:0] word_i,
  input  logic [3:0]  flags_i,
  input  logic [31:0] op_a_i,
  input  logic [31:0] op_b_i,
  output logic        valid_o,
  output logic [3:0]  rd_o,
  output logic [3:0]  rn_o,
  output logic [3:0]  rm_o,
  output logic [31:0] result_o,
  output logic        unpred_o
);
  dec_t              dec_w;
  logic              cond_ok_w;
  logic              bad_idx_w;
  logic [WORD_W-1:0] lanes_w;

  hsx_decode u_decode (.fmt_i(fmt_sel_i), .word_i(word_i), .dec_o(dec_w));
  hsx_cond   u_cond   (.cond_i(dec_w.cond), .flags_i(flags_i), .pass_o(cond_ok_w));
  hsx_lanes #(.HW(HALF_W)) u_lanes (.a_i(op_a_i), .b_i(op_b_i), .res_o(lanes_w));

  always_comb begin
    bad_idx_w = (dec_w.rn == '1) || (dec_w.rd == '1) || (dec_w.rm == '1);
    valid_o   = dec_w.hit && cond_ok_w;
    result_o  = valid_o ? lanes_w : '0;
    rd_o      = dec_w.rd;
    rn_o      = dec_w.rn;
    rm_o      = dec_w.rm;
    unpred_o  = dec_w.hit && (bad_idx_w || dec_w.pad_bad);
  end

  always_comb begin
    if (!$isunknown({fmt_sel_i, word_i, flags_i, op_a_i, op_b_i})) begin
      // R8
      write_gate_chk: assert (valid_o || result_o == '0)
        else $error("result leaked without write enable");
      // R6
      idx15_chk: assert (!(dec_w.hit && (rd_o == 4'd15 || rn_o == 4'd15 || rm_o == 4'd15)) || unpred_o)
        else $error("index 15 not flagged");
      // R9
      pair_pass_chk: assert (!(dec_w.hit && fmt_sel_i == FMT_PAIR) || valid_o)
        else $error("pair format blocked by condition");
      // R10
      miss_quiet_chk: assert (dec_w.hit || (!valid_o && !unpred_o))
        else $error("flags raised on a miss");
    end
  end
endmodule

// File: tb/test_hsx_top.sv
module test_hsx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_sel = 1'b0;
  logic [31:0] word = '0;
  logic [3:0]  flags = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        valid, unpred;
  logic [3:0]  rd, rn, rm;
  logic [31:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hsx_top i_hsx_top (
    .fmt_sel_i(fmt_sel), .word_i(word), .flags_i(flags), .op_a_i(op_a), .op_b_i(op_b),
    .valid_o(valid), .rd_o(rd), .rn_o(rn), .rm_o(rm), .result_o(result), .unpred_o(unpred));

  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'd0: return z;          4'd1: return !z;
      4'd2: return cy;         4'd3: return !cy;
      4'd4: return n;          4'd5: return !n;
      4'd6: return v;          4'd7: return !v;
      4'd8: return cy && !z;   4'd9: return !cy || z;
      4'd10: return n == v;    4'd11: return n != v;
      4'd12: return !z && n == v;
      4'd13: return z || n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] ref_result(input logic [31:0] a, input logic [31:0] b);
    int s, d;
    s = int'(a[15:0]) + int'(b[31:16]);
    d = int'(a[31:16]) - int'(b[15:0]);
    return {16'((d >>> 1) & 32'hFFFF), 16'(s / 2)};
  endfunction

  function automatic logic [31:0] enc_word(input logic [3:0] c, input logic [3:0] n,
                                           input logic [3:0] d, input logic [3:0] m);
    return {c, 8'b0110_0111, n, d, 4'hF, 4'b0101, m};
  endfunction

  function automatic logic [31:0] enc_pair(input logic [3:0] n, input logic [3:0] d,
                                           input logic [3:0] m);
    return {12'hFAE, n, 4'hF, d, 4'h6, m};
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // apply inputs on the falling edge, sample 2 ns later (outputs are combinational, R11)
  task automatic run(input string tag, input bit f, input logic [31:0] w, input logic [3:0] fl,
                     input logic [31:0] a, input logic [31:0] b);
    bit hit, ok, un;
    logic [3:0] en, ed, em;
    @(negedge clk);
    fmt_sel = f; word = w; flags = fl; op_a = a; op_b = b;
    #2;
    hit = 0; en = 0; ed = 0; em = 0; ok = 0; un = 0;
    if (!f && (w & 32'h0FF000F0) == 32'h06700050 && w[31:28] != 4'hF) begin
      hit = 1; en = w[19:16]; ed = w[15:12]; em = w[3:0];
      ok = cond_ok(w[31:28], fl);
      un = (w[11:8] != 4'hF);
    end else if (f && (w & 32'hFFF0F0F0) == 32'hFAE0F060) begin
      hit = 1; en = w[19:16]; ed = w[11:8]; em = w[3:0]; ok = 1;
    end
    if (hit && (en == 15 || ed == 15 || em == 15)) un = 1;
    cmp(tag, "valid", {31'b0, valid}, {31'b0, hit && ok});
    cmp(tag, "unpred", {31'b0, unpred}, {31'b0, un});
    cmp(tag, "idx", {20'b0, rn, rd, rm}, {20'b0, en, ed, em});
    cmp(tag, "result", result, (hit && ok) ? ref_result(a, b) : 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R10 idle/reset state: all-zero word is a miss
    run("R10", 0, 32'h0, 4'h0, 32'h0, 32'h0);
    // R1 R2 corners
    run("R1", 0, enc_word(4'hE, 1, 2, 3), 4'h0, 32'h0, 32'h0);
    run("R1", 0, enc_word(4'hE, 1, 2, 3), 4'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R1", 1, enc_pair(4, 5, 6), 4'h0, 32'h0000_FFFF, 32'h0001_0000);
    run("R2", 1, enc_pair(4, 5, 6), 4'h0, 32'h0000_0000, 32'h0000_0001);
    run("R2", 0, enc_word(4'hE, 0, 0, 0), 4'h0, 32'h0000_1234, 32'h0000_FFFF);
    run("R2", 0, enc_word(4'hE, 7, 8, 9), 4'h0, 32'hFFFF_0000, 32'h0000_0000);
    // R7 R8: every condition code against every flag set
    for (int c = 0; c < 16; c++)
      for (int fl = 0; fl < 16; fl++)
        run(c == 15 ? "R3" : "R7", 0, enc_word(4'(c), 1, 2, 3), 4'(fl),
            32'h8001_7FFF, 32'h7FFF_8001);
    // R9: flags ignored in pair format
    for (int fl = 0; fl < 16; fl++)
      run("R9", 1, enc_pair(3, 2, 1), 4'(fl), 32'hABCD_1234, 32'h5678_9ABC);
    // R5 filler bits
    for (int p = 0; p < 15; p++)
      run("R5", 0, enc_word(4'hE, 1, 2, 3) & ~32'h0F00 | (32'(p) << 8), 4'h0,
          32'h1111_2222, 32'h3333_4444);
    // R6 index 15 and 13
    run("R6", 0, enc_word(4'hE, 15, 2, 3), 4'h0, 32'h1, 32'h2);
    run("R6", 0, enc_word(4'hE, 1, 15, 3), 4'h0, 32'h1, 32'h2);
    run("R6", 1, enc_pair(1, 2, 15), 4'h0, 32'h1, 32'h2);
    run("R6", 1, enc_pair(13, 13, 13), 4'h0, 32'h1, 32'h2);
    run("R6", 0, enc_word(4'hE, 13, 13, 13), 4'h0, 32'h1, 32'h2);
    // R3 R4: single fixed-bit flips and wrong format select
    for (int k = 0; k < 200; k++) begin
      logic [31:0] w;
      int bitn;
      bit f = 1'($urandom);
      w = f ? enc_pair(4'($urandom), 4'($urandom), 4'($urandom))
            : enc_word(4'($urandom_range(0, 14)), 4'($urandom), 4'($urandom), 4'($urandom));
      bitn = $urandom_range(0, 31);
      if ($urandom_range(0, 3) != 0) w[bitn] = ~w[bitn];
      if ($urandom_range(0, 7) == 0) f = ~f;
      run(f ? "R4" : "R3", f, w, 4'($urandom), $urandom, $urandom);
    end
    // R1 R2 R11 random operands, both formats
    for (int k = 0; k < 600; k++) begin
      bit f = 1'(k & 1);
      run(f ? "R4" : "R3", f,
          f ? enc_pair(4'($urandom), 4'($urandom), 4'($urandom))
            : enc_word(4'($urandom_range(0, 14)), 4'($urandom), 4'($urandom), 4'($urandom)),
          4'($urandom), $urandom, $urandom);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule